// File: doc/BRIEF.md
# Glitch-Free Clock Select and Gate

This block picks one of two free-running clocks and drives it onto a single output clock. The output never carries a runt pulse, whether the choice of source changes or the enable stops or restarts it. In the default synchronous mode each input has its own gating path. A path's enable is carried through a short chain of flops clocked on that input's falling edge. One path is always turned off before the other can turn on, so the output parks low while the handover is in progress. The same enable chain also serves as a clean gate: dropping the enable stops the output after a falling edge, and raising it restarts the output on a rising edge.

A build-time mode parameter can replace all of this with a plain combinational multiplexer and gate. That variant has no switching latency, but it may glitch. The select input must change in step with the clock that is currently selected. The enable must change in step with the ungated clock that it gates. Reset is asynchronous and active low, and it forces the output low.

Top module: `clk_select_gate`

## Requirements
- R1: While `rst_n` is 0 the output is 0. After release with `sel`=0 and `ce`=1, the first output rising edge is the `clk0` rising edge that follows the second `clk0` falling edge after release.
- R2: In synchronous mode, `sel`=0 routes `clk0` to `clk_out` and `sel`=1 routes `clk1`, each at that input's own period.
- R3: In synchronous mode no high or low phase of `clk_out` is shorter than the shorter half-period of the two inputs, across switches in either direction and across gating.
- R4: The two input paths are never enabled at the same time. During a switch the output stays low from the old source's last falling edge until the new path has seen two falling edges of its own clock.
- R5: With `ce`=0 (1 means run), the output is held at 0 with no edges, starting at most two falling edges of the selected clock later.
- R6: When `ce` drops while the output is high, that high phase completes at full width. Gating acts only at a falling edge of the input clock.
- R7: When `ce` returns to 1, the output resumes at the period of the selected clock.
- R8: If `sel` changes while `ce`=0, the output restarts from the newly selected clock once `ce` returns to 1.
- R9: With MODE set to the asynchronous variant, `clk_out` equals `rst_n & ce & (sel ? clk1 : clk0)` at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Source clock chosen when sel is 0 |
| clk1 | input | 1 | Source clock chosen when sel is 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select, synchronous to the selected clock |
| ce | input | 1 | Output enable, synchronous to the ungated clock |
| clk_out | output | 1 | Selected and gated clock |

## Verification
The two sources run at unrelated periods, so every handover meets a different phase offset. A monitor timestamps every output edge and records the shortest phase. A design that lets both paths overlap, or that changes its enable while a clock is high, would show a sliver shorter than either half-period. The low gap across each switch is measured against the two-falling-edge handover: a path that turned on before the other had shut off would shorten the gap or merge two clocks. The bench drops the enable mid-high-phase to catch gating on the wrong edge, which would show up as a clipped high pulse. It also changes `sel` while gated, to catch a design that restarts on the stale source.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic {
        MUX_SYNC  = 1'b0,
        MUX_ASYNC = 1'b1
    } mux_mode_e;

    typedef struct packed {
        logic want;
        logic en;
    } leg_state_t;

    // Request for path idx: selected and enabled.
    function automatic logic leg_want(input logic sel, input logic ce, input int idx);
        return ce && (sel == (idx != 0));
    endfunction

endpackage

// File: rtl/clksel_leg.sv
module clksel_leg
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic want_i,
    input  logic block_i,
    output logic en_o,
    output logic gclk_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic             req;
    logic [LAST:0]    sync_q;
    leg_state_t       st;

    assign req = want_i && !block_i;

    // Enable chain on the falling edge: the enable only moves while clk_i is low.
    generate
        if (SYNC_STAGES >= 2) begin : g_chain
            always_ff @(negedge clk_i or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[LAST-1:0], req};
            end
        end else begin : g_single
            always_ff @(negedge clk_i or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= req;
            end
        end
    endgenerate

    always_comb begin
        st.want = req;
        st.en   = sync_q[LAST];
    end

    assign en_o   = st.en;
    assign gclk_o = clk_i & st.en;

    generate
        if (SYNC_STAGES == 2) begin : g_chk
            // R5: no request -> path off two falling edges later
            p_off_after_drop_r5: assert property (@(negedge clk_i) disable iff (!rst_n)
                !want_i |-> ##2 !en_o);
            // R4: other path live -> this path is off two falling edges later
            p_yield_r4: assert property (@(negedge clk_i) disable iff (!rst_n)
                block_i |-> ##2 !en_o);
        end
    endgenerate

endmodule

// File: rtl/clk_select_gate.sv
module clk_select_gate
    import clksel_pkg::*;
#(
    parameter mux_mode_e MODE        = MUX_SYNC,
    parameter int        SYNC_STAGES = 2
) (
    input  logic clk0,
    input  logic clk1,
    input  logic rst_n,
    input  logic sel,
    input  logic ce,
    output logic clk_out
);

    localparam int NUM_SRC = 2;

    generate
        if (MODE == MUX_SYNC) begin : g_sync
            logic [NUM_SRC-1:0] src;
            logic [NUM_SRC-1:0] en;
            logic [NUM_SRC-1:0] gclk;

            assign src = {clk1, clk0};

            for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
                clksel_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
                    .clk_i   (src[i]),
                    .rst_n   (rst_n),
                    .want_i  (leg_want(sel, ce, i)),
                    .block_i (en[NUM_SRC-1-i]),
                    .en_o    (en[i]),
                    .gclk_o  (gclk[i])
                );
            end

            assign clk_out = |gclk;

            // R4: paths mutually exclusive, seen from each domain
            p_excl_clk0_r4: assert property (@(posedge clk0) disable iff (!rst_n)
                en[1] |-> !en[0]);
            p_excl_clk1_r4: assert property (@(posedge clk1) disable iff (!rst_n)
                en[0] |-> !en[1]);
        end else begin : g_async
            // R9: plain gated mux, may glitch
            assign clk_out = rst_n & ce & (sel ? clk1 : clk0);
        end
    endgenerate

endmodule

// File: tb/clk_select_gate_test.sv
`timescale 1ns/1ps
module clk_select_gate_test;
    import clksel_pkg::*;

    localparam real HALF0 = 4.0;   // 125 MHz
    localparam real HALF1 = 6.5;   // unrelated second source
    localparam real TOL   = 0.01;

    logic clk0 = 1'b0;
    logic clk1 = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic ce = 1'b1;
    logic clk_out;
    logic clk_out_raw;

    int checks = 0;
    int errors = 0;

    always #(HALF0) clk0 = ~clk0;
    initial begin
        #1.3;
        forever #(HALF1) clk1 = ~clk1;
    end

    clk_select_gate #(.MODE(MUX_SYNC)) uut (
        .clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sel(sel), .ce(ce), .clk_out(clk_out));

    clk_select_gate #(.MODE(MUX_ASYNC)) uut_raw (
        .clk0(clk0), .clk1(clk1), .rst_n(rst_n), .sel(sel), .ce(ce), .clk_out(clk_out_raw));

    // Edge monitor on the safe output
    bit  mon_on = 0;
    bit  have_last = 0;
    real t_last = 0.0, min_ph = 1.0e9, last_hi = 0.0, max_lo = 0.0;
    real t_rise = 0.0, per_last = 0.0;
    int  rise_cnt = 0;

    always @(clk_out) begin
        if (mon_on) begin
            if (have_last) begin
                real w;
                w = $realtime - t_last;
                if (w < min_ph) min_ph = w;
                if (clk_out == 1'b0) last_hi = w;
                else if (w > max_lo) max_lo = w;
            end
            if (clk_out == 1'b1) begin
                rise_cnt++;
                per_last = $realtime - t_rise;
                t_rise = $realtime;
            end
            have_last = 1;
            t_last = $realtime;
        end
    end

    // Raw-mode monitor, sampled just after any source edge
    int raw_samples = 0, raw_bad = 0;
    always @(clk0 or clk1) begin
        #0.05;
        if (rst_n) begin
            raw_samples++;
            if (clk_out_raw !== (ce & (sel ? clk1 : clk0))) raw_bad++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0.3f expected=%0.3f", req, what, act, exp);
        end
    endtask

    task automatic check_period(input real exp, input string req);
        repeat (4) @(posedge clk_out);
        #0.05;
        check((per_last > exp - TOL) && (per_last < exp + TOL), req, "output period", per_last, exp);
    endtask

    task automatic t_reset;
        int n;
        #30;
        check(clk_out === 1'b0, "R1", "output during reset", real'(clk_out), 0.0);
        #20;                       // t=50, away from clk0 edges
        rst_n = 1'b1;
        mon_on = 1;
        n = 0;
        while (clk_out !== 1'b1) begin
            @(negedge clk0 or posedge clk_out);
            if (clk_out !== 1'b1) n++;
        end
        check(n == 2, "R1", "clk0 falling edges before first output edge", real'(n), 2.0);
    endtask

    task automatic t_switch;
        check_period(2.0 * HALF0, "R2");
        @(posedge clk0); #1;
        max_lo = 0.0;
        sel = 1'b1;
        check_period(2.0 * HALF1, "R2");
        check(max_lo >= HALF1 + 2.0 * HALF1 - TOL, "R4", "low gap switching to clk1",
              max_lo, HALF1 + 2.0 * HALF1);
        @(posedge clk1); #1;
        max_lo = 0.0;
        sel = 1'b0;
        check_period(2.0 * HALF0, "R2");
        check(max_lo >= HALF0 + 2.0 * HALF0 - TOL, "R4", "low gap switching to clk0",
              max_lo, HALF0 + 2.0 * HALF0);
    endtask

    task automatic t_gate;
        int snap;
        @(posedge clk0); #1;
        ce = 1'b0;
        repeat (4) @(negedge clk0);
        #0.5;
        snap = rise_cnt;
        check(clk_out === 1'b0, "R5", "output level while gated", real'(clk_out), 0.0);
        check((last_hi > HALF0 - TOL) && (last_hi < HALF0 + TOL), "R6",
              "last high phase before stop", last_hi, HALF0);
        #200;
        check(rise_cnt == snap, "R5", "rising edges while gated", real'(rise_cnt - snap), 0.0);
        @(posedge clk0); #1;
        ce = 1'b1;
        check_period(2.0 * HALF0, "R7");
    endtask

    task automatic t_sel_while_gated;
        int snap;
        @(posedge clk0); #1;
        ce = 1'b0;
        repeat (4) @(negedge clk0);
        @(posedge clk0); #1;
        sel = 1'b1;
        repeat (3) @(posedge clk1);
        #0.5;
        snap = rise_cnt;
        check(clk_out === 1'b0, "R8", "output low after select change while gated",
              real'(clk_out), 0.0);
        #100;
        check(rise_cnt == snap, "R5", "edges while gated after select change",
              real'(rise_cnt - snap), 0.0);
        @(posedge clk1); #1;
        ce = 1'b1;
        check_period(2.0 * HALF1, "R8");
    endtask

    task automatic t_phases_and_raw;
        check(min_ph >= HALF0 - TOL, "R3", "shortest output phase", min_ph, HALF0);
        check(raw_samples > 100, "R9", "raw-mode samples taken", real'(raw_samples), 100.0);
        check(raw_bad == 0, "R9", "raw-mode mismatches", real'(raw_bad), 0.0);
    endtask

    initial begin
        t_reset();
        t_switch();
        t_gate();
        t_sel_while_gated();
        t_phases_and_raw();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule